// File: doc/BRIEF.md
# Fuse Programming Sequencer

This block drives the one-time programming of a small fuse array that holds a 256-bit secret key, a 32-bit user word and six protection flags. It reaches the array through a simple field-oriented fuse port, which offers a combinational read, a one-cycle program strobe and a combinational verify result. It also reaches a device identity register through a separate read port. A caller presents a request and pulses `start`. The sequencer then confirms the device identity, resets the configuration logic and reads back what the array already holds. Next it decides whether the request is needed, allowed and possible, and only then blows fuses, in a fixed order.

The user word is split in two parts. The upper 24 bits form a field that can be programmed on its own. The low byte always travels with the key. Protection flag positions are: bit 0 key read lock, bit 1 user read lock, bit 2 key/user write lock, bit 3 flag write lock, and bits 4 and 5 are boot policy flags with no effect on the sequencer.

At the end the block reports a 3-bit outcome and a 9-bit vector of planned writes. It also shows the key and user word it read, hiding any field whose read lock is blown. Request inputs must be held stable from `start` until `done`.

Top module: `fuse_prog_seq`

## Requirements
- R1: After reset `busy`, `done`, `result`, `plan` and every port strobe are 0.
- R2: A run makes `ID_READS` identity reads, then one `cfg_rst` cycle, then the four field reads. Programming follows in this order: test fuses, key, user low byte, user upper bits, protection flags. `done` is a one-cycle pulse.
- R3: If any identity read has bit 0 clear, or differs from the first read, the result is 2 and no fuse is programmed.
- R4: When every requested value is already present, the result is 0 and nothing is programmed.
- R5: Test fuses (field 4) are blown only when the whole array reads blank. When the array is partly programmed, that step is skipped.
- R6: A key request is refused with code 2, before any fuse is touched, if the request does not also set the key read lock and `unsafe_ok` is low. With `unsafe_ok` high it proceeds.
- R7: With `wr_en` low, a request that needs writes ends with code 2, writes nothing and still reports `plan`. `plan` bit 0 is the key, bit 1 the user upper bits, bit 2 the user low byte, and bits 8:3 are the flag bits to add.
- R8: On a non-blank array, the key/low byte or the user upper bits can be programmed only if they are still zero and flags 0, 1 and 2 are all clear. New flags can be added only while flag 3 is clear. Any breach gives code 2.
- R9: A key or user verify failure does not stop flag programming, and gives code 4 when the flags succeed. A flag verify failure gives code 5.
- R10: A failed test-fuse verify gives code 3 and ends the run.
- R11: `out_key` reads as zero when flag 0 is set, and `out_user` reads as zero when flag 1 is set.
- R12: A permitted request that programs without error gives code 1, and the key and user low byte are both written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| wr_en | input | 1 | Permit real fuse writes |
| unsafe_ok | input | 1 | Override the key read-lock safety rule |
| req_key_en | input | 1 | Request key and user low byte |
| req_key | input | KEY_W | Requested key |
| req_uhi_en | input | 1 | Request user upper bits |
| req_user | input | USER_W | Requested user word |
| req_ctrl | input | CTRL_W | Protection flags to be set |
| id_rd | output | 1 | Identity read strobe |
| id_data | input | ID_W | Identity value |
| cfg_rst | output | 1 | Configuration reset pulse |
| fz_rd | output | 1 | Fuse field read strobe |
| fz_pgm | output | 1 | Fuse field program strobe |
| fz_sel | output | 3 | Field: 0 key, 1 user upper, 2 user low, 3 flags, 4 test |
| fz_wdata | output | KEY_W | Bits to blow, right-aligned |
| fz_rdata | input | KEY_W | Field contents, right-aligned |
| fz_ok | input | 1 | Verify result of the current program strobe |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 3 | Outcome code 0..5 |
| plan | output | 9 | Planned write vector |
| out_key | output | KEY_W | Key as read, masked by read lock |
| out_user | output | USER_W | User word as read, masked by read lock |

## Verification
Counting from the clock edge that accepts `start`, `done` rises 3 edges later on an identity failure and 9 edges later on a refusal or a no-op. A run that programs ends on edge 14, because each of the five program slots takes one cycle whether or not it is used. The outcome, `plan` and read-back values are registered together with `done` and hold until the next start. For that reason the bench waits for the `done` pulse, samples everything on the following falling edge and compares it there. The fuse model counts and logs program strobes at rising edges. This lets the order and absence of writes be checked at the ports after each run.

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq #(
  parameter int KEY_W    = 256,
  parameter int USER_W   = 32,
  parameter int LO_W     = 8,
  parameter int CTRL_W   = 6,
  parameter int ID_W     = 32,
  parameter int ID_READS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_en,
  input  logic              unsafe_ok,
  input  logic              req_key_en,
  input  logic [KEY_W-1:0]  req_key,
  input  logic              req_uhi_en,
  input  logic [USER_W-1:0] req_user,
  input  logic [CTRL_W-1:0] req_ctrl,
  output logic              id_rd,
  input  logic [ID_W-1:0]   id_data,
  output logic              cfg_rst,
  output logic              fz_rd,
  output logic              fz_pgm,
  output logic [2:0]        fz_sel,
  output logic [KEY_W-1:0]  fz_wdata,
  input  logic [KEY_W-1:0]  fz_rdata,
  input  logic              fz_ok,
  output logic              busy,
  output logic              done,
  output logic [2:0]        result,
  output logic [CTRL_W+2:0] plan,
  output logic [KEY_W-1:0]  out_key,
  output logic [USER_W-1:0] out_user
);
  localparam int HI_W  = USER_W - LO_W;
  localparam int CNT_W = (ID_READS > 5) ? $clog2(ID_READS) : 3;
  localparam int F_RDK = 0, F_RDU = 1, F_WDKU = 2, F_WDC = 3;
  localparam logic [2:0] RC_SAME = 3'd0, RC_OK = 3'd1, RC_BAD = 3'd2,
                         RC_TEST = 3'd3, RC_KU = 3'd4, RC_CTL = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_ID, S_CRST, S_RD, S_CHK, S_PGM} st_t;
  st_t st;
  logic [CNT_W-1:0]  cnt;
  logic [ID_W-1:0]   id_ref;
  logic              id_bad, ku_fail;
  logic [KEY_W-1:0]  cur_key;
  logic [HI_W-1:0]   cur_uhi;
  logic [LO_W-1:0]   cur_ulo;
  logic [CTRL_W-1:0] cur_ctrl;
  logic [4:0]        do_op;

  wire [CTRL_W-1:0] ctrl_add = req_ctrl & ~cur_ctrl;
  wire blank    = ~|cur_key & ~|cur_uhi & ~|cur_ulo & ~|cur_ctrl;
  wire key_need = req_key_en & ((cur_key != req_key) | (cur_ulo != req_user[LO_W-1:0]));
  wire uhi_need = req_uhi_en & (cur_uhi != req_user[USER_W-1:LO_W]);
  wire any_w    = key_need | uhi_need | (|ctrl_add);
  wire lock_ku  = cur_ctrl[F_RDK] | cur_ctrl[F_RDU] | cur_ctrl[F_WDKU];
  wire bad_key  = key_need & ~blank & (lock_ku | (|cur_key) | (|cur_ulo));
  wire bad_uhi  = uhi_need & ~blank & (lock_ku | (|cur_uhi));
  wire bad_ctl  = (|ctrl_add) & cur_ctrl[F_WDC];
  wire leak_key = key_need & ~unsafe_ok & ~req_ctrl[F_RDK];
  wire refuse   = bad_key | bad_uhi | bad_ctl | leak_key | (any_w & ~wr_en);
  wire id_fail  = id_bad | ~id_data[0] | ((cnt != '0) & (id_data != id_ref));
  wire last_id  = cnt == CNT_W'(ID_READS - 1);

  assign busy     = st != S_IDLE;
  assign id_rd    = st == S_ID;
  assign cfg_rst  = st == S_CRST;
  assign fz_rd    = st == S_RD;
  assign fz_pgm   = (st == S_PGM) & do_op[cnt[2:0]];
  assign out_key  = cur_ctrl[F_RDK] ? '0 : cur_key;
  assign out_user = cur_ctrl[F_RDU] ? '0 : {cur_uhi, cur_ulo};

  always_comb begin
    fz_sel   = cnt[2:0];
    fz_wdata = '0;
    if (st == S_PGM) begin
      case (cnt[2:0])
        3'd0:    begin fz_sel = 3'd4; fz_wdata = '1; end
        3'd1:    begin fz_sel = 3'd0; fz_wdata = req_key; end
        3'd2:    begin fz_sel = 3'd2; fz_wdata = KEY_W'(req_user[LO_W-1:0]); end
        3'd3:    begin fz_sel = 3'd1; fz_wdata = KEY_W'(req_user[USER_W-1:LO_W]); end
        default: begin fz_sel = 3'd3; fz_wdata = KEY_W'(ctrl_add); end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; id_ref <= '0; id_bad <= 1'b0; ku_fail <= 1'b0;
      cur_key <= '0; cur_uhi <= '0; cur_ulo <= '0; cur_ctrl <= '0;
      do_op <= '0; done <= 1'b0; result <= RC_SAME; plan <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_ID; cnt <= '0; id_bad <= 1'b0; ku_fail <= 1'b0;
        end
        S_ID: begin
          if (cnt == '0) id_ref <= id_data;
          id_bad <= id_fail;
          cnt <= cnt + 1'b1;
          if (last_id) begin
            cnt <= '0;
            if (id_fail) begin
              st <= S_IDLE; done <= 1'b1; result <= RC_BAD; plan <= '0;
            end else st <= S_CRST;
          end
        end
        S_CRST: st <= S_RD;
        S_RD: begin
          case (cnt[1:0])
            2'd0: cur_key  <= fz_rdata;
            2'd1: cur_uhi  <= fz_rdata[HI_W-1:0];
            2'd2: cur_ulo  <= fz_rdata[LO_W-1:0];
            default: cur_ctrl <= fz_rdata[CTRL_W-1:0];
          endcase
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(3)) begin st <= S_CHK; cnt <= '0; end
        end
        S_CHK: begin
          plan <= {ctrl_add, key_need, uhi_need, key_need};
          if (refuse || !any_w) begin
            st <= S_IDLE; done <= 1'b1; result <= refuse ? RC_BAD : RC_SAME;
          end else begin
            st <= S_PGM; cnt <= '0;
            do_op <= {|ctrl_add, uhi_need, key_need, key_need, blank};
          end
        end
        S_PGM: begin
          cnt <= cnt + 1'b1;
          if (fz_pgm && !fz_ok && cnt == '0) begin
            st <= S_IDLE; done <= 1'b1; result <= RC_TEST;
          end else if (cnt == CNT_W'(4)) begin
            st <= S_IDLE; done <= 1'b1;
            result <= (fz_pgm && !fz_ok) ? RC_CTL : (ku_fail ? RC_KU : RC_OK);
          end else if (fz_pgm && !fz_ok) ku_fail <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_pgm_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fz_pgm |-> wr_en);
  p_key_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fz_pgm && fz_sel == 3'd0) |-> (unsafe_ok || req_ctrl[F_RDK]));
  p_flag_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fz_pgm && fz_sel == 3'd3) |-> !cur_ctrl[F_WDC]);
  p_one_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({id_rd, cfg_rst, fz_rd, fz_pgm}));
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_code_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> result <= RC_CTL);
endmodule

// File: tb/fuse_prog_seq_test.sv
module fuse_prog_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic start = 0, wr_en = 0, unsafe_ok = 0, req_key_en = 0, req_uhi_en = 0;
  logic [255:0] req_key = '0;
  logic [31:0]  req_user = '0;
  logic [5:0]   req_ctrl = '0;
  logic id_rd, cfg_rst, fz_rd, fz_pgm, fz_ok, busy, done;
  logic [31:0] id_data, out_user;
  logic [2:0] fz_sel, result;
  logic [255:0] fz_wdata, fz_rdata, out_key;
  logic [8:0] plan;

  fuse_prog_seq uut (.clk, .rst_n, .start, .wr_en, .unsafe_ok, .req_key_en, .req_key,
    .req_uhi_en, .req_user, .req_ctrl, .id_rd, .id_data, .cfg_rst, .fz_rd, .fz_pgm,
    .fz_sel, .fz_wdata, .fz_rdata, .fz_ok, .busy, .done, .result, .plan, .out_key, .out_user);

  logic prep = 0, id_flip = 0;
  logic [31:0] id_val = 32'h1357_9BDF;
  logic [31:0] p_k = 0, p_u = 0;
  logic [5:0]  p_c = 0;
  logic [4:0]  fault = 0;
  logic [255:0] m_key;
  logic [23:0] m_uhi;
  logic [7:0]  m_ulo;
  logic [5:0]  m_ctrl;
  logic        m_test;
  int n_pgm, n_id, n_cfg;
  logic [14:0] plog;

  assign id_data = id_val ^ ((id_flip && n_id == 2) ? 32'h10 : 32'h0);
  assign fz_ok = (fz_sel < 3'd5) ? !fault[fz_sel] : 1'b1;
  always_comb begin
    case (fz_sel)
      3'd0: fz_rdata = m_key;
      3'd1: fz_rdata = 256'(m_uhi);
      3'd2: fz_rdata = 256'(m_ulo);
      3'd3: fz_rdata = 256'(m_ctrl);
      default: fz_rdata = 256'(m_test);
    endcase
  end

  always @(posedge clk) begin
    if (prep) begin
      m_key <= {8{p_k}}; m_uhi <= p_u[31:8]; m_ulo <= p_u[7:0]; m_ctrl <= p_c; m_test <= 0;
      n_pgm <= 0; n_id <= 0; n_cfg <= 0; plog <= 0;
    end else begin
      if (id_rd) n_id <= n_id + 1;
      if (cfg_rst) n_cfg <= n_cfg + 1;
      if (fz_pgm) begin
        n_pgm <= n_pgm + 1;
        plog <= {plog[11:0], fz_sel};
        if (!fault[fz_sel]) case (fz_sel)
          3'd0: m_key <= m_key | fz_wdata;
          3'd1: m_uhi <= m_uhi | fz_wdata[23:0];
          3'd2: m_ulo <= m_ulo | fz_wdata[7:0];
          3'd3: m_ctrl <= m_ctrl | fz_wdata[5:0];
          default: m_test <= 1'b1;
        endcase
      end
    end
  end

  int checks = 0, fails = 0;
  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] pk; logic [31:0] pu; logic [5:0] pc;
    logic ke; logic [31:0] rk; logic ue; logic [31:0] ru; logic [5:0] rc;
    logic we; logic us; logic [4:0] ft;
    logic [2:0] er; logic [3:0] en; logic [8:0] ep;
  } vec_t;

  localparam vec_t TBL [13] = '{
    '{32'h0, 32'h0, 6'h00, 1, 32'hA5A5_0001, 1, 32'h1234_5678, 6'h01, 1, 0, 5'h00, 3'd1, 4'd5, 9'h00F},
    '{32'h0, 32'h0, 6'h00, 1, 32'hA5A5_0001, 1, 32'h1234_5678, 6'h00, 1, 0, 5'h00, 3'd2, 4'd0, 9'h007},
    '{32'h0, 32'h0, 6'h00, 1, 32'hA5A5_0001, 1, 32'h1234_5678, 6'h00, 1, 1, 5'h00, 3'd1, 4'd4, 9'h007},
    '{32'h0, 32'h0, 6'h00, 1, 32'hA5A5_0001, 1, 32'h1234_5678, 6'h01, 0, 0, 5'h00, 3'd2, 4'd0, 9'h00F},
    '{32'hA5A5_0001, 32'h1234_5678, 6'h01, 1, 32'hA5A5_0001, 1, 32'h1234_5678, 6'h01, 1, 0, 5'h00, 3'd0, 4'd0, 9'h000},
    '{32'h0, 32'h0, 6'h10, 0, 32'h0, 1, 32'hABCD_EF00, 6'h00, 1, 0, 5'h00, 3'd1, 4'd1, 9'h002},
    '{32'h0, 32'h0000_0100, 6'h00, 0, 32'h0, 1, 32'hABCD_EF00, 6'h00, 1, 0, 5'h00, 3'd2, 4'd0, 9'h002},
    '{32'h0, 32'h0, 6'h08, 0, 32'h0, 0, 32'h0, 6'h02, 1, 0, 5'h00, 3'd2, 4'd0, 9'h010},
    '{32'h0, 32'h0, 6'h04, 1, 32'hA5A5_0001, 0, 32'h0000_0078, 6'h01, 1, 0, 5'h00, 3'd2, 4'd0, 9'h00D},
    '{32'h0, 32'h0, 6'h00, 1, 32'hA5A5_0001, 1, 32'h1234_5678, 6'h01, 1, 0, 5'h02, 3'd4, 4'd5, 9'h00F},
    '{32'h0, 32'h0, 6'h00, 1, 32'hA5A5_0001, 1, 32'h1234_5678, 6'h01, 1, 0, 5'h08, 3'd5, 4'd5, 9'h00F},
    '{32'h0, 32'h0, 6'h00, 1, 32'hA5A5_0001, 1, 32'h1234_5678, 6'h01, 1, 0, 5'h10, 3'd3, 4'd1, 9'h00F},
    '{32'hCAFE_0001, 32'h8765_4321, 6'h03, 0, 32'h0, 0, 32'h0, 6'h00, 1, 0, 5'h00, 3'd0, 4'd0, 9'h000}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 2:  return "R12";
      1:     return "R6";
      3:     return "R7";
      4:     return "R4";
      5:     return "R5";
      6, 7, 8: return "R8";
      9, 10: return "R9";
      11:    return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic run(vec_t v);
    @(negedge clk);
    p_k = v.pk; p_u = v.pu; p_c = v.pc; fault = v.ft;
    req_key_en = v.ke; req_key = {8{v.rk}}; req_uhi_en = v.ue; req_user = v.ru;
    req_ctrl = v.rc; wr_en = v.we; unsafe_ok = v.us; prep = 1;
    @(negedge clk); prep = 0; start = 1;
    @(negedge clk); start = 0;
    for (int t = 0; t < 100 && !done; t++) @(negedge clk);
    chk("R2 done", done, 1'b1);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 result", result, 0);
    chk("R1 plan", plan, 0); chk("R1 strobes", {id_rd, cfg_rst, fz_rd, fz_pgm}, 0);
    rst_n = 1;
    for (int i = 0; i < 13; i++) begin
      run(TBL[i]);
      chk({tag_of(i), " result"}, result, TBL[i].er);
      chk({tag_of(i), " program count"}, n_pgm, TBL[i].en);
      chk({tag_of(i), " plan"}, plan, TBL[i].ep);
      chk("R11 out_key", out_key, TBL[i].pc[0] ? 256'h0 : {8{TBL[i].pk}});
      chk("R11 out_user", out_user, TBL[i].pc[1] ? 32'h0 : TBL[i].pu);
      if (i == 0) begin
        chk("R2 identity reads", n_id, 3);
        chk("R2 config reset", n_cfg, 1);
        chk("R2 R5 order", plog, {3'd4, 3'd0, 3'd2, 3'd1, 3'd3});
        chk("R12 key written", m_key, {8{32'hA5A5_0001}});
        chk("R12 low byte written", m_ulo, 8'h78);
      end
      if (i == 5) chk("R5 no test fuse", plog, 15'(3'd1));
      if (i == 9) chk("R9 flags still written", m_ctrl, 6'h01);
    end
    id_flip = 1;
    run(TBL[0]);
    chk("R3 id mismatch result", result, 2); chk("R3 id mismatch writes", n_pgm, 0);
    id_flip = 0; id_val = 32'h1357_9BDE;
    run(TBL[0]);
    chk("R3 id bit0 result", result, 2); chk("R3 id bit0 writes", n_pgm, 0);
    @(negedge clk);
    chk("R2 done single", done, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule